// File: doc/BRIEF.md
# Burst Terminate Generator

This block sits on the slave side of a pipelined on-chip bus and decides the one cycle in which a burst should be cut short, separately for the read and the write data paths. A transfer on a path begins when the address phase is acknowledged for that direction, or when the bus promotes a queued transfer on that path to primary. At that moment the block latches the terminate settings that apply to the transfer. After that it watches the path's data acknowledges and its complete strobe, and it raises that path's terminate output for a single cycle.

Two sources can request a terminate. In programmed mode a per-transfer enable and a target count decide the cycle. The count advances either on every clock of the data phase or on each data acknowledge. In fixed-length mode the block works out the burst length from the byte enables and terminates with the second-to-last data acknowledge. This mode applies only when the mode input is set, the byte enables are non-zero and the size code marks a burst. A target that lies outside the legal window moves to the nearest legal cycle. A target of zero moves to the first cycle after the start. A target that has not been reached by the time the transfer completes moves to the complete cycle.

Top module: `bterm_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_bterm` and `wr_bterm` are 0.
- R2: A read transfer starts on a clock edge where `addr_ack`=1 with `addr_rnw`=1, or where `rd_prim`=1. A write transfer starts where `addr_ack`=1 with `addr_rnw`=0, or where `wr_prim`=1. `term_en`, `count_dack`, `term_count`, `fixed_mode`, `byte_en` and `size_code` are sampled only at the start, so later changes to them do not affect that transfer.
- R3: A terminate output is never high in the cycle that starts its transfer. The earliest terminate is the cycle after the start, even when the target count is 0.
- R4: With `count_dack`=0 (clock base), the programmed terminate is high in the k-th cycle after the start, where k = max(`term_count`,1).
- R5: With `count_dack`=1 (acknowledge base), the programmed terminate is high in the cycle of the k-th data acknowledge after the start, where k = max(`term_count`,1).
- R6: When `term_en`=0 at the start and fixed-length mode does not qualify, the terminate output stays low for the whole transfer.
- R7: Fixed-length mode qualifies when `fixed_mode`=1, `byte_en` is non-zero and `size_code[3]`=1. The burst length is N = `byte_en[3:0]`, and the terminate is high with data acknowledge number max(N-1,1).
- R8: When `byte_en` is zero or `size_code[3]`=0, fixed-length mode does not terminate, even if `fixed_mode`=1.
- R9: If a transfer with a terminate source (programmed or fixed) reaches its complete strobe without having terminated, the terminate output is high in the cycle of the complete strobe.
- R10: Each transfer produces at most one terminate cycle. After the complete strobe, further data acknowledges produce no terminate until a new transfer starts.
- R11: The read and write paths are independent. Traffic, complete strobes and terminates on one path never change the other path's terminate.
- R12: The cycle and acknowledge counts saturate at their maximum (2^CNT_W - 1). A target equal to that maximum still terminates when the count reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_ack | input | 1 | Address phase acknowledged this cycle |
| addr_rnw | input | 1 | Direction of the acknowledged address: 1 read, 0 write |
| rd_prim | input | 1 | Queued read promoted to primary this cycle |
| wr_prim | input | 1 | Queued write promoted to primary this cycle |
| size_code | input | SIZE_W | Transfer size code; bit 3 set marks a burst |
| byte_en | input | BE_W | Byte enables; low LEN_W bits give the fixed burst length |
| term_en | input | 1 | Programmed terminate enabled for this transfer |
| count_dack | input | 1 | Count base: 0 clocks, 1 data acknowledges |
| term_count | input | CNT_W | Programmed terminate target |
| fixed_mode | input | 1 | Fixed-length mode enable |
| rd_dack | input | 1 | Read data acknowledge |
| wr_dack | input | 1 | Write data acknowledge |
| rd_comp | input | 1 | Read transfer complete |
| wr_comp | input | 1 | Write transfer complete |
| rd_bterm | output | 1 | Read burst terminate |
| wr_bterm | output | 1 | Write burst terminate |

## Verification
The bench builds the block with CNT_W=4 and the other widths at their defaults. The narrow counter lets a short run reach saturation: it uses a target of 15 in acknowledge base and a fixed length of 15, so the sticky top of the counter is exercised (R12). It also tests a programmed target of 12 that is cut short by an early complete, which exercises the late clamp. A behavioural model holds each path's transfer state in integers and predicts both terminate outputs every cycle. The scenarios cover both count bases, both ways a transfer can start, disqualified fixed bursts, and reads and writes running at the same time.

// File: rtl/bterm_pkg.sv
package bterm_pkg;
   typedef enum logic {
      CB_CLOCK = 1'b0,
      CB_DACK  = 1'b1
   } count_base_e;

   localparam int unsigned CH_RD = 0;
   localparam int unsigned CH_WR = 1;
   localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/bt_sat_counter.sv
module bt_sat_counter #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (inc && (q != TOP)) begin
         q <= q + 1'b1;
      end
   end
endmodule

// File: rtl/bt_fire_logic.sv
module bt_fire_logic
   import bterm_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             act,
   input  logic             done,
   input  count_base_e      base,
   input  logic             prog_en,
   input  logic             fix_en,
   input  logic [CNT_W-1:0] prog_tgt,
   input  logic [CNT_W-1:0] fix_tgt,
   input  logic [CNT_W-1:0] cyc_cnt,
   input  logic [CNT_W-1:0] ack_cnt,
   input  logic             dack,
   input  logic             comp,
   output logic             fire
);
   logic [CNT_W:0] ack_incl;
   logic           prog_hit;
   logic           fix_hit;
   logic           late_hit;

   always_comb begin
      ack_incl = {1'b0, ack_cnt} + {{CNT_W{1'b0}}, 1'b1};
      if (base == CB_DACK) begin
         prog_hit = prog_en && dack && (ack_incl >= {1'b0, prog_tgt});
      end else begin
         prog_hit = prog_en && (cyc_cnt >= prog_tgt);
      end
      fix_hit  = fix_en && dack && (ack_incl >= {1'b0, fix_tgt});
      late_hit = (prog_en || fix_en) && comp;
      fire     = act && !done && (prog_hit || fix_hit || late_hit);
   end
endmodule

// File: rtl/bt_channel.sv
module bt_channel
   import bterm_pkg::*;
#(
   parameter int unsigned CNT_W     = 6,
   parameter int unsigned BE_W      = 16,
   parameter int unsigned LEN_W     = 4,
   parameter int unsigned SIZE_W    = 4,
   parameter int unsigned BURST_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_en,
   input  logic              cfg_dack,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_fixed,
   input  logic [BE_W-1:0]   cfg_be,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic              dack,
   input  logic              comp,
   output logic              bterm
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             act_q;
   logic             done_q;
   count_base_e      base_q;
   logic             en_q;
   logic             fix_q;
   logic [CNT_W-1:0] ptgt_q;
   logic [CNT_W-1:0] ftgt_q;
   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] ack_cnt;

   logic             fix_ok;
   logic [CNT_W-1:0] len_ext;
   logic [CNT_W-1:0] ptgt_d;
   logic [CNT_W-1:0] ftgt_d;
   logic             fire;

   always_comb begin
      fix_ok  = cfg_fixed && (|cfg_be) && cfg_size[BURST_BIT];
      len_ext = {{(CNT_W-LEN_W){1'b0}}, cfg_be[LEN_W-1:0]};
      ptgt_d  = (cfg_count == '0) ? ONE : cfg_count;
      ftgt_d  = (len_ext <= (ONE + ONE)) ? ONE : (len_ext - ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         done_q <= 1'b0;
         base_q <= CB_CLOCK;
         en_q   <= 1'b0;
         fix_q  <= 1'b0;
         ptgt_q <= ONE;
         ftgt_q <= ONE;
      end else if (start) begin
         act_q  <= 1'b1;
         done_q <= 1'b0;
         base_q <= cfg_dack ? CB_DACK : CB_CLOCK;
         en_q   <= cfg_en;
         fix_q  <= fix_ok;
         ptgt_q <= ptgt_d;
         ftgt_q <= ftgt_d;
      end else begin
         if (comp) begin
            act_q <= 1'b0;
         end
         if (fire) begin
            done_q <= 1'b1;
         end
      end
   end

   bt_sat_counter #(.W(CNT_W)) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (ONE),
      .inc      (act_q),
      .q        (cyc_cnt)
   );

   bt_sat_counter #(.W(CNT_W)) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val ('0),
      .inc      (act_q && dack),
      .q        (ack_cnt)
   );

   bt_fire_logic #(.CNT_W(CNT_W)) u_fire (
      .act      (act_q),
      .done     (done_q),
      .base     (base_q),
      .prog_en  (en_q),
      .fix_en   (fix_q),
      .prog_tgt (ptgt_q),
      .fix_tgt  (ftgt_q),
      .cyc_cnt  (cyc_cnt),
      .ack_cnt  (ack_cnt),
      .dack     (dack),
      .comp     (comp),
      .fire     (fire)
   );

   assign bterm = fire && !start;
endmodule

// File: rtl/bterm_gen.sv
module bterm_gen
   import bterm_pkg::*;
#(
   parameter int unsigned CNT_W     = 6,
   parameter int unsigned BE_W      = 16,
   parameter int unsigned LEN_W     = 4,
   parameter int unsigned SIZE_W    = 4,
   parameter int unsigned BURST_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_ack,
   input  logic              addr_rnw,
   input  logic              rd_prim,
   input  logic              wr_prim,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [BE_W-1:0]   byte_en,
   input  logic              term_en,
   input  logic              count_dack,
   input  logic [CNT_W-1:0]  term_count,
   input  logic              fixed_mode,
   input  logic              rd_dack,
   input  logic              wr_dack,
   input  logic              rd_comp,
   input  logic              wr_comp,
   output logic              rd_bterm,
   output logic              wr_bterm
);
   if (LEN_W > BE_W) begin : g_bad_len
      $error("bterm_gen: LEN_W must not exceed BE_W");
   end
   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("bterm_gen: CNT_W must be at least LEN_W");
   end
   if (BURST_BIT >= SIZE_W) begin : g_bad_size
      $error("bterm_gen: BURST_BIT must index into size_code");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("bterm_gen: CNT_W must be at least 2");
   end

   logic [N_CH-1:0] start_v;
   logic [N_CH-1:0] dack_v;
   logic [N_CH-1:0] comp_v;
   logic [N_CH-1:0] bterm_v;

   always_comb begin
      start_v[CH_RD] = (addr_ack && addr_rnw) || rd_prim;
      start_v[CH_WR] = (addr_ack && !addr_rnw) || wr_prim;
      dack_v[CH_RD]  = rd_dack;
      dack_v[CH_WR]  = wr_dack;
      comp_v[CH_RD]  = rd_comp;
      comp_v[CH_WR]  = wr_comp;
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      bt_channel #(
         .CNT_W     (CNT_W),
         .BE_W      (BE_W),
         .LEN_W     (LEN_W),
         .SIZE_W    (SIZE_W),
         .BURST_BIT (BURST_BIT)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (start_v[g]),
         .cfg_en    (term_en),
         .cfg_dack  (count_dack),
         .cfg_count (term_count),
         .cfg_fixed (fixed_mode),
         .cfg_be    (byte_en),
         .cfg_size  (size_code),
         .dack      (dack_v[g]),
         .comp      (comp_v[g]),
         .bterm     (bterm_v[g])
      );
   end

   assign rd_bterm = bterm_v[CH_RD];
   assign wr_bterm = bterm_v[CH_WR];
endmodule

// File: rtl/bterm_gen_chk.sv
module bterm_gen_chk #(
   parameter int unsigned CNT_W     = 6,
   parameter int unsigned BE_W      = 16,
   parameter int unsigned LEN_W     = 4,
   parameter int unsigned SIZE_W    = 4,
   parameter int unsigned BURST_BIT = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_ack,
   input logic              addr_rnw,
   input logic              rd_prim,
   input logic              wr_prim,
   input logic [SIZE_W-1:0] size_code,
   input logic [BE_W-1:0]   byte_en,
   input logic              term_en,
   input logic              count_dack,
   input logic [CNT_W-1:0]  term_count,
   input logic              fixed_mode,
   input logic              rd_dack,
   input logic              wr_dack,
   input logic              rd_comp,
   input logic              wr_comp,
   input logic              rd_bterm,
   input logic              wr_bterm
);
   logic [1:0] beg_v, ack_v, end_v, out_v;
   logic       fix_q;

   always_comb begin
      beg_v = {(addr_ack && !addr_rnw) || wr_prim, (addr_ack && addr_rnw) || rd_prim};
      ack_v = {wr_dack, rd_dack};
      end_v = {wr_comp, rd_comp};
      out_v = {wr_bterm, rd_bterm};
      fix_q = fixed_mode && (|byte_en) && size_code[BURST_BIT];
   end

   for (genvar c = 0; c < 2; c++) begin : g_c
      logic infl, fired, k_dack, k_en, k_fix;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            infl <= 1'b0; fired <= 1'b0;
            k_dack <= 1'b0; k_en <= 1'b0; k_fix <= 1'b0;
         end else if (beg_v[c]) begin
            infl <= 1'b1; fired <= 1'b0;
            k_dack <= count_dack; k_en <= term_en; k_fix <= fix_q;
         end else begin
            if (end_v[c]) infl <= 1'b0;
            if (out_v[c]) fired <= 1'b1;
         end
      end

      // R3: terminate only for a transfer started in an earlier cycle
      assert_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
         out_v[c] |-> (infl && !beg_v[c]));
      // R10: one terminate per transfer
      assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         out_v[c] |-> !fired);
      // R6: no source, no terminate
      assert_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (infl && !k_en && !k_fix) |-> !out_v[c]);
      // R5: acknowledge-based terminates line up with an acknowledge or the complete
      assert_ack_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (infl && (k_dack || !k_en) && out_v[c]) |-> (ack_v[c] || end_v[c]));
      // R9: late clamp at complete
      assert_late_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (infl && !beg_v[c] && end_v[c] && (k_en || k_fix) && !fired) |-> out_v[c]);
   end
endmodule

bind bterm_gen bterm_gen_chk #(
   .CNT_W(CNT_W), .BE_W(BE_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .BURST_BIT(BURST_BIT)
) u_chk (.*);

// File: tb/tb_bterm_gen.sv
`timescale 1ns/1ps
module tb_bterm_gen;
   localparam int CW   = 4;
   localparam int BEW  = 16;
   localparam int SW   = 4;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_ack = 0, addr_rnw = 0, rd_prim = 0, wr_prim = 0;
   logic [SW-1:0] size_code = '0;
   logic [BEW-1:0] byte_en = '0;
   logic term_en = 0, count_dack = 0, fixed_mode = 0;
   logic [CW-1:0] term_count = '0;
   logic rd_dack = 0, wr_dack = 0, rd_comp = 0, wr_comp = 0;
   logic rd_bterm, wr_bterm;

   always #2 clk = ~clk;

   bterm_gen #(.CNT_W(CW), .BE_W(BEW), .LEN_W(4), .SIZE_W(SW), .BURST_BIT(3)) dut (
      .clk(clk), .rst_n(rst_n), .addr_ack(addr_ack), .addr_rnw(addr_rnw),
      .rd_prim(rd_prim), .wr_prim(wr_prim), .size_code(size_code), .byte_en(byte_en),
      .term_en(term_en), .count_dack(count_dack), .term_count(term_count),
      .fixed_mode(fixed_mode), .rd_dack(rd_dack), .wr_dack(wr_dack),
      .rd_comp(rd_comp), .wr_comp(wr_comp), .rd_bterm(rd_bterm), .wr_bterm(wr_bterm));

   int n_cmp = 0, n_bad = 0, cycles = 0;
   string cur_req = "R1";

   // reference model, index 0 read, 1 write
   int m_act[2], m_done[2], m_dk[2], m_en[2], m_fix[2], m_tp[2], m_tf[2], m_cyc[2], m_ack[2];

   function automatic bit m_start(int c);
      if (c == 0) return (addr_ack && addr_rnw) || rd_prim;
      return (addr_ack && !addr_rnw) || wr_prim;
   endfunction

   function automatic bit m_expect(int c);
      bit dk, cp, hit;
      dk = (c == 0) ? rd_dack : wr_dack;
      cp = (c == 0) ? rd_comp : wr_comp;
      if (!rst_n || !m_act[c] || m_done[c] || m_start(c)) return 1'b0;
      hit = 1'b0;
      if (m_en[c] && m_dk[c] && dk && (m_ack[c] + 1 >= m_tp[c])) hit = 1'b1;
      if (m_en[c] && !m_dk[c] && (m_cyc[c] >= m_tp[c])) hit = 1'b1;
      if (m_fix[c] && dk && (m_ack[c] + 1 >= m_tf[c])) hit = 1'b1;
      if ((m_en[c] || m_fix[c]) && cp) hit = 1'b1;
      return hit;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      for (int c = 0; c < 2; c++) begin
         if (!rst_n) begin
            m_act[c] = 0; m_done[c] = 0; m_cyc[c] = 0; m_ack[c] = 0;
            m_en[c] = 0; m_fix[c] = 0; m_dk[c] = 0; m_tp[c] = 1; m_tf[c] = 1;
         end else begin
            bit fire, dk, cp;
            int len;
            fire = m_expect(c);
            dk = (c == 0) ? rd_dack : wr_dack;
            cp = (c == 0) ? rd_comp : wr_comp;
            if (m_start(c)) begin
               len = int'(byte_en[3:0]);
               m_act[c] = 1; m_done[c] = 0; m_cyc[c] = 1; m_ack[c] = 0;
               m_en[c] = term_en; m_dk[c] = count_dack;
               m_tp[c] = (term_count == 0) ? 1 : int'(term_count);
               m_fix[c] = fixed_mode && (byte_en != 0) && size_code[3];
               m_tf[c] = (len <= 2) ? 1 : len - 1;
            end else if (m_act[c]) begin
               if (fire) m_done[c] = 1;
               if (cp) m_act[c] = 0;
               if (m_cyc[c] < MAXC) m_cyc[c]++;
               if (dk && m_ack[c] < MAXC) m_ack[c]++;
            end
         end
      end
   end

   always @(negedge clk) begin
      bit er, ew;
      cycles++;
      er = m_expect(0);
      ew = m_expect(1);
      n_cmp++;
      if (rd_bterm !== er) begin
         n_bad++;
         $display("FAIL %s rd_bterm at cycle %0d: actual %b expected %b", cur_req, cycles, rd_bterm, er);
      end
      n_cmp++;
      if (wr_bterm !== ew) begin
         n_bad++;
         $display("FAIL %s wr_bterm at cycle %0d: actual %b expected %b", cur_req, cycles, wr_bterm, ew);
      end
      if (cycles > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   // rd=1 read path; prim=1 start via promotion instead of address acknowledge
   task automatic begin_txn(bit rd, bit prim, bit dkm, bit en, int t, bit fx, int be, int sz);
      term_en = en; count_dack = dkm; term_count = CW'(t);
      fixed_mode = fx; byte_en = BEW'(be); size_code = SW'(sz);
      if (prim) begin
         if (rd) rd_prim = 1; else wr_prim = 1;
      end else begin
         addr_ack = 1; addr_rnw = rd;
      end
      tick(1);
      addr_ack = 0; rd_prim = 0; wr_prim = 0;
   endtask

   task automatic step(bit rd, bit dk, bit cp);
      if (rd) begin rd_dack = dk; rd_comp = cp; end
      else    begin wr_dack = dk; wr_comp = cp; end
      tick(1);
      rd_dack = 0; rd_comp = 0; wr_dack = 0; wr_comp = 0;
   endtask

   // acks every cycle, complete with the last
   task automatic run_acks(bit rd, int n);
      for (int i = 1; i <= n; i++) step(rd, 1'b1, i == n);
   endtask

   initial begin
      cur_req = "R1";
      tick(3);
      rst_n = 1;
      tick(2);

      cur_req = "R4";             // clock base, target 3, six idle cycles then complete
      begin_txn(1, 0, 0, 1, 3, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(1, 0, 0);
      step(1, 0, 1); tick(1);

      cur_req = "R3";             // target 0 clamps to first cycle after start
      begin_txn(0, 0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0); step(0, 0, 0); step(0, 0, 1); tick(1);

      cur_req = "R5";             // acknowledge base, target 2, sparse acks
      begin_txn(1, 0, 1, 1, 2, 0, 0, 0);
      step(1, 0, 0); step(1, 1, 0); step(1, 0, 0); step(1, 1, 0); step(1, 1, 0); step(1, 1, 1); tick(1);

      cur_req = "R6";             // nothing enabled
      begin_txn(1, 0, 0, 0, 1, 0, 15, 8);
      run_acks(1, 5); tick(1);

      cur_req = "R7";             // fixed write, length 4, terminate on third ack
      begin_txn(0, 0, 0, 0, 0, 1, 16'h00F4, 4'b1010);
      step(0, 0, 0); run_acks(0, 4); tick(1);
      cur_req = "R7";             // fixed length 1 clamps to first ack
      begin_txn(1, 0, 0, 0, 0, 1, 16'h0001, 4'b1000);
      step(1, 1, 1); tick(1);

      cur_req = "R8";             // byte enables zero
      begin_txn(1, 0, 0, 0, 0, 1, 0, 4'b1010);
      run_acks(1, 4); tick(1);
      cur_req = "R8";             // size code not a burst
      begin_txn(0, 0, 0, 0, 0, 1, 16'h0004, 4'b0010);
      run_acks(0, 4); tick(1);

      cur_req = "R9";             // target 12, complete at cycle 5
      begin_txn(1, 0, 0, 1, 12, 0, 0, 0);
      for (int i = 0; i < 4; i++) step(1, 0, 0);
      step(1, 0, 1); tick(1);

      cur_req = "R10";            // fires early, more acks, then acks after complete
      begin_txn(0, 0, 1, 1, 1, 0, 0, 0);
      run_acks(0, 4);
      step(0, 1, 0); step(0, 1, 0); step(0, 0, 1); tick(1);

      cur_req = "R2";             // promotion start, settings changed after start
      begin_txn(1, 1, 0, 1, 4, 0, 0, 0);
      term_count = 1; term_en = 0; count_dack = 1;
      for (int i = 0; i < 5; i++) step(1, 0, 0);
      step(1, 0, 1);
      cur_req = "R2";
      begin_txn(0, 1, 1, 1, 2, 0, 0, 0);
      term_en = 0;
      run_acks(0, 3); tick(1);

      cur_req = "R11";            // both paths together
      term_en = 1; count_dack = 0; term_count = 2; fixed_mode = 0;
      addr_ack = 1; addr_rnw = 1; tick(1);
      addr_ack = 0; count_dack = 1; term_count = 3; wr_prim = 1; tick(1);
      wr_prim = 0;
      for (int i = 0; i < 5; i++) begin
         rd_dack = 1; wr_dack = (i != 1); rd_comp = (i == 2); wr_comp = (i == 4);
         tick(1);
      end
      rd_dack = 0; wr_dack = 0; rd_comp = 0; wr_comp = 0; tick(2);

      cur_req = "R12";            // saturating counts
      begin_txn(1, 0, 1, 1, 15, 0, 0, 0);
      run_acks(1, 18); tick(1);
      begin_txn(0, 0, 0, 0, 0, 1, 16'h000F, 4'b1100);
      run_acks(0, 16); tick(1);
      begin_txn(1, 0, 0, 1, 15, 0, 0, 0);
      for (int i = 0; i < 19; i++) step(1, 0, 0);
      step(1, 0, 1); tick(2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule